// File: doc/BRIEF.md
# Transmit FIFO Fill-Level Mismatch Monitor

This block sits beside the three transmit lanes of one serial port. It holds the small first-in first-out queues that feed the three transmitters. It also compares their fill levels on every cycle. When the lanes in use stop holding equal amounts of data, it raises one of two flags. One flag covers lane 1 and the other covers lane 2. Lane 0 is the usual reference for both. If lane 0 is switched off, lane 2 is compared against lane 1 instead. A lane whose transmitter is disabled is never used as a reference.

The flags are combinational: they follow the current levels, the three lane enables and the FIFO-mode enable. They are held low while the port is in reset. The flags also appear in a 16-bit status word at the bit positions a status register decoder expects. Each queue has its own push and pop. A push into a full queue is discarded, and so is a pop from an empty queue. The queue depth is a parameter and must be a power of two.

Top module: `txmon_top`

## Requirements
- R1: `mis_f1` is high exactly when `lane_en[1]`, `lane_en[0]` and `fifo_mode` are all high and the level of lane 1 differs from the level of lane 0.
- R2: `mis_f1` stays low whenever `lane_en[0]` is low, whatever the levels are.
- R3: With `lane_en[0]` high, `mis_f2` is high exactly when `lane_en[2]` and `fifo_mode` are high and the level of lane 2 differs from the level of lane 0.
- R4: With `lane_en[0]` low and `lane_en[1]` high, `mis_f2` is high exactly when `lane_en[2]` and `fifo_mode` are high and the level of lane 2 differs from the level of lane 1.
- R5: `mis_f2` stays low whenever `lane_en[0]` and `lane_en[1]` are both low.
- R6: Both flags are low while `fifo_mode` is low.
- R7: While `rst_n` is low, both flags are low and every level reads zero.
- R8: In `stat_word`, bit 9 equals `mis_f1`, bit 8 equals `mis_f2`, and every other bit is zero.
- R9: A push into a full queue is discarded. The level stays at DEPTH and the stored data is unchanged.
- R10: A pop from an empty queue is discarded, and the level stays at zero.
- R11: Each queue returns its data in the order it was pushed. Its level is the number of pushes accepted minus the number of pops accepted. The lane with index i uses bits [i*W +: W] of `wdata`, `rdata` and `level`, and bit i of `lane_en`, `push`, `pop`, `full` and `empty`. `rdata` shows the oldest entry without a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous port reset |
| lane_en | input | 3 | Transmitter enable for each lane |
| fifo_mode | input | 1 | FIFO mode enable |
| push | input | 3 | Push request for each lane |
| pop | input | 3 | Pop request for each lane |
| wdata | input | 3*DW | Write data, packed by lane |
| rdata | output | 3*DW | Oldest entry of each lane, packed by lane |
| level | output | 3*LW | Fill level of each lane, LW = log2(DEPTH)+1 |
| full | output | 3 | Lane queue holds DEPTH entries |
| empty | output | 3 | Lane queue holds no entries |
| mis_f1 | output | 1 | Lane 1 level mismatch flag |
| mis_f2 | output | 1 | Lane 2 level mismatch flag |
| stat_word | output | 16 | Status word carrying the two flags at bits 9 and 8 |

## Verification
The states that are hardest to reach from the ports are the ones with three different levels at once. These are needed to tell whether lane 2 was compared with lane 0 or with lane 1. Levels can only be changed by pushes, one per cycle. The bench therefore resets the block and then pushes a separate count into each lane. It does this for every combination of levels from zero to DEPTH. For each combination it sweeps all sixteen settings of the lane enables and FIFO mode, and it computes the expected flags from the level arithmetic. Separate sequences fill one queue past full and drain it past empty, to check that it ignores the extra requests and keeps its data order.

// File: rtl/txmon_pkg.sv
package txmon_pkg;

  typedef enum logic [1:0] {
    REF_NONE = 2'd0,
    REF_L0   = 2'd1,
    REF_L1   = 2'd2
  } ref_sel_e;

  localparam int STAT_W   = 16;
  localparam int STAT_F1  = 9;
  localparam int STAT_F2  = 8;
  localparam int NUM_LANE = 3;

  // Reference lane for the lane-2 comparison: first enabled of lane 0, lane 1
  function automatic ref_sel_e lane2_ref(input logic en0, input logic en1);
    if (en0)      return REF_L0;
    else if (en1) return REF_L1;
    else          return REF_NONE;
  endfunction

  // A lane takes part in checking only with port out of reset and FIFO mode on
  function automatic logic lane_live(input logic en, input logic mode, input logic run);
    return en & mode & run;
  endfunction

endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (level == LW'(DEPTH)));

  a_r10_empty_pop_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (level == '0));

  a_r11_push_pop_balance: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> $stable(level));

endmodule

// File: rtl/lvl_cmp.sv
module lvl_cmp
  import txmon_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic [2:0]    en,
  input  logic [LW-1:0] lvl0,
  input  logic [LW-1:0] lvl1,
  input  logic [LW-1:0] lvl2,
  output logic          f1,
  output logic          f2
);

  ref_sel_e      ref2;
  logic          live1, live2;
  logic [LW-1:0] ref2_lvl;
  logic          ref2_valid;

  assign live1 = lane_live(en[1], mode, rst_n);
  assign live2 = lane_live(en[2], mode, rst_n);
  assign ref2  = lane2_ref(en[0], en[1]);

  always_comb begin
    ref2_valid = 1'b1;
    unique case (ref2)
      REF_L0:  ref2_lvl = lvl0;
      REF_L1:  ref2_lvl = lvl1;
      default: begin
        ref2_lvl   = lvl2;
        ref2_valid = 1'b0;
      end
    endcase
  end

  assign f1 = live1 && en[0] && (lvl1 != lvl0);
  assign f2 = live2 && ref2_valid && (lvl2 != ref2_lvl);

  always_comb begin
    if (!rst_n) a_r7_quiet_in_reset: assert (!f1 && !f2);
  end

  a_r1_f1_means_diff: assert property (@(posedge clk) disable iff (!rst_n)
    f1 |-> (lvl1 != lvl0));

  a_r2_f1_needs_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0] |-> !f1);

  a_r5_f2_needs_reference: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[0] && !en[1]) |-> !f2);

  a_r6_mode_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> !(f1 || f2));

  a_r4_f2_lane1_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (f2 && !en[0]) |-> (lvl2 != lvl1));

endmodule

// File: rtl/txmon_top.sv
module txmon_top
  import txmon_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          lane_en,
  input  logic                fifo_mode,
  input  logic [2:0]          push,
  input  logic [2:0]          pop,
  input  logic [3*DW-1:0]     wdata,
  output logic [3*DW-1:0]     rdata,
  output logic [3*LW-1:0]     level,
  output logic [2:0]          full,
  output logic [2:0]          empty,
  output logic                mis_f1,
  output logic                mis_f2,
  output logic [STAT_W-1:0]   stat_word
);

  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    lane_fifo #(.DEPTH(DEPTH), .DW(DW)) fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[g]),
      .pop   (pop[g]),
      .wdata (wdata[g*DW +: DW]),
      .rdata (rdata[g*DW +: DW]),
      .level (level[g*LW +: LW]),
      .full  (full[g]),
      .empty (empty[g])
    );
  end

  lvl_cmp #(.LW(LW)) cmp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (fifo_mode),
    .en    (lane_en),
    .lvl0  (level[0*LW +: LW]),
    .lvl1  (level[1*LW +: LW]),
    .lvl2  (level[2*LW +: LW]),
    .f1    (mis_f1),
    .f2    (mis_f2)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[STAT_F1] = mis_f1;
    stat_word[STAT_F2] = mis_f2;
  end

  a_r7_levels_clear: assert property (@(posedge clk)
    !rst_n |-> (level == '0));

endmodule

// File: tb/txmon_top_tb_top.sv
module txmon_top_tb_top;

  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [2:0]        lane_en;
  logic              fifo_mode;
  logic [2:0]        push, pop;
  logic [3*DW-1:0]   wdata;
  logic [3*DW-1:0]   rdata;
  logic [3*LW-1:0]   level;
  logic [2:0]        full, empty;
  logic              mis_f1, mis_f2;
  logic [15:0]       stat_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  txmon_top #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .fifo_mode(fifo_mode),
    .push(push), .pop(pop), .wdata(wdata), .rdata(rdata), .level(level),
    .full(full), .empty(empty), .mis_f1(mis_f1), .mis_f2(mis_f2),
    .stat_word(stat_word)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push = '0; pop = '0;
    #1;
    chk("R7 flags in reset", {30'd0, mis_f1, mis_f2}, 32'd0);
    chk("R7 levels in reset", 32'(level), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [LW-1:0] lv(input int i);
    return level[i*LW +: LW];
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lane_en = '0; fifo_mode = 1'b0;
    push = '0; pop = '0; wdata = '0;
    // Sweep all level triples and all control settings (R1..R8, R11 levels)
    for (int n0 = 0; n0 <= DEPTH; n0++)
      for (int n1 = 0; n1 <= DEPTH; n1++)
        for (int n2 = 0; n2 <= DEPTH; n2++) begin
          do_reset();
          for (int k = 0; k < DEPTH; k++) begin
            push  = {3'(k < n2), 3'(k < n1) & 3'd1, 3'(k < n0) & 3'd1} & 3'b111;
            push  = {(k < n2), (k < n1), (k < n0)};
            wdata = {8'(k + 32), 8'(k + 16), 8'(k)};
            @(negedge clk);
          end
          push = '0;
          chk("R11 level lane0", 32'(lv(0)), 32'(n0));
          chk("R11 level lane1", 32'(lv(1)), 32'(n1));
          chk("R11 level lane2", 32'(lv(2)), 32'(n2));
          for (int c = 0; c < 16; c++) begin
            logic e0, e1, e2, md, x1, x2;
            {md, e2, e1, e0} = 4'(c);
            lane_en = {e2, e1, e0}; fifo_mode = md;
            #1;
            x1 = e0 && e1 && md && (n1 != n0);
            if (e0)      x2 = e2 && md && (n2 != n0);
            else if (e1) x2 = e2 && md && (n2 != n1);
            else         x2 = 1'b0;
            if (!e0) chk("R2 f1 lane0 off", 32'(mis_f1), 32'(x1));
            else     chk("R1 f1 vs lane0", 32'(mis_f1), 32'(x1));
            if (!md)          chk("R6 mode off f2", 32'(mis_f2), 32'(x2));
            else if (e0)      chk("R3 f2 vs lane0", 32'(mis_f2), 32'(x2));
            else if (e1)      chk("R4 f2 vs lane1", 32'(mis_f2), 32'(x2));
            else              chk("R5 f2 no ref", 32'(mis_f2), 32'(x2));
            chk("R8 stat word", 32'(stat_word), 32'({x1, x2}) << 8);
          end
          // Mismatched levels must vanish in reset (R7)
          lane_en = 3'b111; fifo_mode = 1'b1;
          if (n0 != n1 && n1 == 1 && n2 == 0) do_reset();
        end

    // Overflow, order and underflow on lane 1 (R9, R10, R11)
    do_reset();
    lane_en = 3'b000; fifo_mode = 1'b0;
    for (int k = 0; k < DEPTH + 2; k++) begin
      push = 3'b010; wdata = {8'h00, 8'(8'hA0 + k), 8'h00};
      @(negedge clk);
    end
    push = '0;
    chk("R9 level held at full", 32'(lv(1)), 32'(DEPTH));
    chk("R9 full flag", 32'(full[1]), 32'd1);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R11 order / R9 data kept", 32'(rdata[DW +: DW]), 32'(8'hA0 + k));
      pop = 3'b010;
      @(negedge clk);
      pop = '0;
    end
    chk("R11 drained", 32'(lv(1)), 32'd0);
    pop = 3'b010;
    @(negedge clk);
    @(negedge clk);
    pop = '0;
    chk("R10 level after empty pop", 32'(lv(1)), 32'd0);
    chk("R10 empty flag", 32'(empty[1]), 32'd1);
    push = 3'b010; wdata = {8'h00, 8'h5C, 8'h00};
    @(negedge clk);
    push = '0;
    chk("R10 pointer intact", 32'(rdata[DW +: DW]), 32'h5C);
    chk("R10 level one", 32'(lv(1)), 32'd1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule